// File: doc/BRIEF.md
# Conditional Indirect Branch Unit

This block is the execute step for the branch-to-count-register instruction. Each cycle it registers an instruction word together with the current instruction address, the 32-bit condition register and the 64-bit count register. From that registered set it works out, without further clocking, whether the branch is taken, which address comes next and whether a return address goes to the link register. Bit numbering in the instruction word and the condition register is big-endian: bit 0 is the most significant bit.

The count register only supplies the jump target. It is never decremented and never tested. The decision depends on one condition-register bit and the two most significant option bits. A word that is not this instruction is reported as such and falls through to the next sequential address. An idle cycle (valid low) changes no state downstream.

Top module: `ctr_branch_unit`

## Requirements
- R1: The word is recognised only when instr[31:26] equals 19 and instr[10:1] equals 528. A valid word that fails this test raises `other_o` one cycle later, keeps `taken_o` and `lnk_we_o` low and gives `nia_o` = address + 4.
- R2: When option bit instr[25] (option value 0b10000) is 1, a recognised word is taken whatever the condition register holds.
- R3: When instr[25] is 0, the word is taken exactly when the condition-register bit selected by the index instr[20:16] equals instr[24] (option value 0b01000). Index 0 is cr[31] and index 31 is cr[0].
- R4: A taken branch sets `nia_o` to the low 32 bits of the count register with bits 1:0 cleared. Count-register bits above 31 have no effect.
- R5: Option bits instr[23:21] have no effect on any output.
- R6: `lnk_we_o` is 1 only for a taken branch whose link flag instr[0] is 1, and `lnk_data_o` is then the instruction address + 4. A branch that is not taken never writes the link register, even when the link flag is 1.
- R7: A recognised branch that is not taken gives `taken_o` = 0 and `nia_o` = address + 4, wrapping modulo 2^32.
- R8: With `in_valid` low, the next cycle shows `taken_o`, `lnk_we_o` and `other_o` all at 0.
- R9: While `rst_n` is low at a clock edge, the following cycle shows `taken_o`, `lnk_we_o` and `other_o` all at 0.
- R10: All outputs reflect the inputs sampled at the most recent rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input set is meaningful this cycle |
| in_instr | input | 32 | Instruction word, bit 31 = big-endian bit 0 |
| in_cia | input | 32 | Address of the current instruction |
| in_cr | input | 32 | Condition register |
| in_ctr | input | 64 | Count register |
| nia_o | output | 32 | Next instruction address |
| taken_o | output | 1 | Branch taken |
| lnk_we_o | output | 1 | Link-register write enable |
| lnk_data_o | output | 32 | Link-register write data |
| other_o | output | 1 | Valid word is not this instruction |

## Verification
Every result (next address, taken flag, link enable and data, mismatch flag) is due in the cycle after the rising edge that captured the inputs. No result needs a second cycle. The bench drives each input set on a falling edge and samples one time unit after the next rising edge. It then compares all five outputs with a behavioural model evaluated on the set just captured. Because a new set is applied every cycle, a stale register or an extra pipeline stage shows up as a mismatch at once. The checker properties use the same one-cycle offset, through `|=>` and `$past` of depth one.

// File: rtl/bcu_pkg.sv
// Shared constants and types for the conditional indirect branch unit.
// Assumes a 32-bit instruction word with big-endian field numbering.
package bcu_pkg;
    localparam int INSTR_W   = 32;
    localparam int CR_BITS   = 32;
    localparam int CR_IDX_W  = $clog2(CR_BITS);
    localparam logic [5:0] PRIMARY_OP = 6'd19;
    localparam logic [9:0] EXTEND_OP  = 10'd528;

    // Fields pulled from the word that the later stages use.
    typedef struct packed {
        logic                is_mine;
        logic                opt_always;
        logic                opt_sense;
        logic [CR_IDX_W-1:0] cr_index;
        logic                link;
    } bcu_fields_t;
endpackage

// File: rtl/bcu_decode.sv
// Recognises the branch-to-count-register word and splits out its fields.
// Assumes instr[31] holds big-endian bit 0. Options bits 2..4 and the
// unused B field are deliberately dropped.
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output bcu_fields_t        fields
);
    // Leftover bits with no meaning for this instruction.
    logic unused_fields;
    assign unused_fields = ^{instr[23:21], instr[15:11]};

    // Pure field extraction and opcode compare.
    always_comb begin
        fields.is_mine    = (instr[31:26] == PRIMARY_OP) && (instr[10:1] == EXTEND_OP);
        fields.opt_always = instr[25];
        fields.opt_sense  = instr[24];
        fields.cr_index   = instr[20:16];
        fields.link       = instr[0];
    end
endmodule

// File: rtl/bcu_cond.sv
// Evaluates the branch condition from one condition-register bit.
// Assumes index 0 names the most significant register bit.
module bcu_cond
    import bcu_pkg::*;
(
    input  logic [CR_BITS-1:0]  cr,
    input  logic [CR_IDX_W-1:0] cr_index,
    input  logic                opt_always,
    input  logic                opt_sense,
    output logic                cond_ok
);
    logic [CR_IDX_W-1:0] lsb_index;
    logic                sel_bit;

    // Convert big-endian index to a vector position and test it.
    always_comb begin
        lsb_index = CR_IDX_W'(CR_BITS - 1) - cr_index;
        sel_bit   = cr[lsb_index];
        cond_ok   = opt_always | (sel_bit == opt_sense);
    end
endmodule

// File: rtl/bcu_target.sv
// Forms the next address and the return address.
// Assumes ADDR_W <= CTR_W; count bits above ADDR_W are ignored.
module bcu_target #(
    parameter int ADDR_W = 32,
    parameter int CTR_W  = 64
) (
    input  logic [ADDR_W-1:0] cia,
    input  logic [CTR_W-1:0]  ctr,
    input  logic              take,
    output logic [ADDR_W-1:0] nia,
    output logic [ADDR_W-1:0] ret_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic unused_ctr_hi;
    logic [ADDR_W-1:0] aligned;

    generate
        if (CTR_W > ADDR_W) begin : g_wide_ctr
            assign unused_ctr_hi = ^ctr[CTR_W-1:ADDR_W];
        end else begin : g_same_ctr
            assign unused_ctr_hi = 1'b0;
        end
    endgenerate

    // Round the target down to a word boundary and pick the next address.
    always_comb begin
        aligned  = {ctr[ADDR_W-1:2], 2'b00};
        ret_addr = cia + STEP;
        nia      = take ? aligned : ret_addr;
    end
endmodule

// File: rtl/ctr_branch_unit.sv
// Conditional indirect branch execute step. Registers its inputs once,
// then decides taken / next address / link write combinationally.
// Assumes synchronous active-low reset and a 32-bit condition register.
module ctr_branch_unit
    import bcu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CTR_W  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  in_instr,
    input  logic [ADDR_W-1:0]   in_cia,
    input  logic [CR_BITS-1:0]  in_cr,
    input  logic [CTR_W-1:0]    in_ctr,
    output logic [ADDR_W-1:0]   nia_o,
    output logic                taken_o,
    output logic                lnk_we_o,
    output logic [ADDR_W-1:0]   lnk_data_o,
    output logic                other_o
);
    logic               valid_q;
    logic [INSTR_W-1:0] instr_q;
    logic [ADDR_W-1:0]  cia_q;
    logic [CR_BITS-1:0] cr_q;
    logic [CTR_W-1:0]   ctr_q;

    bcu_fields_t fields;
    logic        cond_ok;
    logic        take;

    // Capture the input set; only the valid bit needs clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            instr_q <= '0;
            cia_q   <= '0;
            cr_q    <= '0;
            ctr_q   <= '0;
        end else begin
            valid_q <= in_valid;
            instr_q <= in_instr;
            cia_q   <= in_cia;
            cr_q    <= in_cr;
            ctr_q   <= in_ctr;
        end
    end

    bcu_decode u_decode (
        .instr  (instr_q),
        .fields (fields)
    );

    bcu_cond u_cond (
        .cr         (cr_q),
        .cr_index   (fields.cr_index),
        .opt_always (fields.opt_always),
        .opt_sense  (fields.opt_sense),
        .cond_ok    (cond_ok)
    );

    bcu_target #(
        .ADDR_W (ADDR_W),
        .CTR_W  (CTR_W)
    ) u_target (
        .cia      (cia_q),
        .ctr      (ctr_q),
        .take     (take),
        .nia      (nia_o),
        .ret_addr (lnk_data_o)
    );

    // Qualify the decision and link write with the registered valid.
    always_comb begin
        take     = valid_q & fields.is_mine & cond_ok;
        taken_o  = take;
        lnk_we_o = take & fields.link;
        other_o  = valid_q & ~fields.is_mine;
    end
endmodule

// File: rtl/ctr_branch_unit_sva.sv
// Checker for ctr_branch_unit: relates outputs to the inputs captured one
// clock earlier. Bound into every instance of the top module.
module ctr_branch_unit_sva #(
    parameter int ADDR_W = 32,
    parameter int CTR_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       in_instr,
    input logic [ADDR_W-1:0] in_cia,
    input logic [CTR_W-1:0]  in_ctr,
    input logic [ADDR_W-1:0] nia_o,
    input logic              taken_o,
    input logic              lnk_we_o,
    input logic [ADDR_W-1:0] lnk_data_o,
    input logic              other_o
);
    logic in_match;
    logic unused_chk;
    assign in_match   = (in_instr[31:26] == 6'd19) && (in_instr[10:1] == 10'd528);
    assign unused_chk = ^{in_instr[24:11], in_ctr};

    AST_LINK_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_we_o |-> taken_o); // R6

    AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (nia_o[1:0] == 2'b00)); // R4

    AST_OTHER_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        other_o |-> (!taken_o && !lnk_we_o)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!taken_o && !lnk_we_o && !other_o)); // R8

    AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_match && in_instr[25]) |=> taken_o); // R2

    AST_LINK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (lnk_data_o == $past(in_cia) + ADDR_W'(4))); // R6

    AST_FALLTHRU_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken_o || (nia_o == $past(in_cia) + ADDR_W'(4)))); // R7
endmodule

bind ctr_branch_unit ctr_branch_unit_sva #(
    .ADDR_W (ADDR_W),
    .CTR_W  (CTR_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_instr   (in_instr),
    .in_cia     (in_cia),
    .in_ctr     (in_ctr),
    .nia_o      (nia_o),
    .taken_o    (taken_o),
    .lnk_we_o   (lnk_we_o),
    .lnk_data_o (lnk_data_o),
    .other_o    (other_o)
);

// File: tb/ctr_branch_unit_test.sv
// Bench: drives one input set per cycle and compares every output with a
// behavioural model one edge later.
module ctr_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_cia = '0;
    logic [31:0] in_cr = '0;
    logic [63:0] in_ctr = '0;
    logic [31:0] nia_o, lnk_data_o;
    logic        taken_o, lnk_we_o, other_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctr_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_cia(in_cia), .in_cr(in_cr), .in_ctr(in_ctr), .nia_o(nia_o),
        .taken_o(taken_o), .lnk_we_o(lnk_we_o), .lnk_data_o(lnk_data_o),
        .other_o(other_o)
    );

    function automatic logic [31:0] mk(input int opc, input int bo, input int bi,
                                       input int xo, input int lk);
        logic [31:0] w;
        w = 32'(opc) << 26;
        w = w | (32'(bo & 31) << 21) | (32'(bi & 31) << 16);
        w = w | (32'(xo & 1023) << 1) | 32'(lk & 1);
        return w;
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive on falling edge, compare after the capturing edge.
    task automatic step(input string tag, input logic v, input logic [31:0] ins,
                        input logic [31:0] cia, input logic [31:0] cr,
                        input logic [63:0] ctr);
        int  opc, xo, bo, bi;
        bit  mine, cbit, tk, lw;
        logic [31:0] e_nia, e_ret;
        @(negedge clk);
        in_valid = v; in_instr = ins; in_cia = cia; in_cr = cr; in_ctr = ctr;
        @(posedge clk);
        #1;
        opc  = int'(ins >> 26);
        xo   = int'((ins >> 1) & 32'd1023);
        bo   = int'((ins >> 21) & 32'd31);
        bi   = int'((ins >> 16) & 32'd31);
        mine = (opc == 19) && (xo == 528);
        cbit = cr[31 - bi];
        tk   = v && mine && ((bo >= 16) || (cbit == ((bo & 8) != 0)));
        lw   = tk && ins[0];
        e_ret = cia + 32'd4;
        e_nia = tk ? (ctr[31:0] & 32'hFFFF_FFFC) : e_ret;
        cmp(tag, "taken", {31'b0, taken_o}, {31'b0, tk});
        cmp(tag, "lnk_we", {31'b0, lnk_we_o}, {31'b0, lw});
        cmp(tag, "other", {31'b0, other_o}, {31'b0, v && !mine});
        cmp(tag, "nia", nia_o, e_nia);
        if (v) cmp(tag, "lnk_data", lnk_data_o, e_ret);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        // R9: reset with valid high still gives quiet enables
        @(negedge clk);
        in_valid = 1'b1; in_instr = mk(19, 20, 0, 528, 1);
        @(posedge clk); #1;
        cmp("R9", "taken", {31'b0, taken_o}, 32'd0);
        cmp("R9", "lnk_we", {31'b0, lnk_we_o}, 32'd0);
        cmp("R9", "other", {31'b0, other_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;

        // R2 R4: unconditional, misaligned target rounded down
        step("R2_R4", 1, mk(19, 20, 0, 528, 0), 32'h0000_1000, 32'h0, 64'h0000_0000_1234_5677);
        // R6: unconditional call writes return address
        step("R6", 1, mk(19, 20, 0, 528, 1), 32'h0000_2000, 32'h0, 64'h0000_0000_0000_8000);
        // R3: equal on field 1 (index 6), bit set -> taken
        step("R3", 1, mk(19, 12, 6, 528, 1), 32'h0000_3000, 32'h0200_0000, 64'h40);
        // R6 R7: same test, bit clear -> not taken, no link write
        step("R6_R7", 1, mk(19, 12, 6, 528, 1), 32'h0000_3000, 32'hFDFF_FFFF, 64'h40);
        // R3: branch on false, bit clear -> taken
        step("R3", 1, mk(19, 4, 6, 528, 0), 32'h0000_4000, 32'h0, 64'h80);
        // R3: index 0 is the most significant bit
        step("R3", 1, mk(19, 12, 0, 528, 0), 32'h10, 32'h8000_0000, 64'h100);
        step("R3", 1, mk(19, 12, 0, 528, 0), 32'h10, 32'h0000_0001, 64'h100);
        // R3: index 31 is the least significant bit
        step("R3", 1, mk(19, 12, 31, 528, 0), 32'h20, 32'h0000_0001, 64'h104);
        // R5: low option bits do not alter the decision
        step("R5", 1, mk(19, 15, 3, 528, 1), 32'h30, 32'h1000_0000, 64'h200);
        step("R5", 1, mk(19, 8, 3, 528, 1), 32'h30, 32'h1000_0000, 64'h200);
        step("R5", 1, mk(19, 31, 3, 528, 0), 32'h34, 32'h0, 64'h300);
        // R4: count bits above 31 ignored
        step("R4", 1, mk(19, 20, 0, 528, 0), 32'h40, 32'h0, 64'hFFFF_FFFF_0000_0012);
        // R7: not taken wraps the sequential address
        step("R7", 1, mk(19, 12, 2, 528, 0), 32'hFFFF_FFFC, 32'h0, 64'h500);
        // R1: wrong primary opcode and wrong extended opcode
        step("R1", 1, mk(18, 20, 0, 528, 1), 32'h50, 32'h0, 64'h600);
        step("R1", 1, mk(19, 20, 0, 16, 1), 32'h54, 32'h0, 64'h600);
        // R8: idle cycle with a matching word
        step("R8", 0, mk(19, 20, 0, 528, 1), 32'h60, 32'h0, 64'h700);
        // R10: back-to-back sets, each visible exactly one cycle later
        for (int i = 0; i < 32; i++) begin
            step("R10", 1, mk(19, (i % 2) ? 12 : 4, i, 528, i % 3 == 0 ? 1 : 0),
                 32'(i * 8), 32'hA5C3_0F96, 64'(i * 20 + 3));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule